// File: doc/BRIEF.md
# Dual prescaled down-counting timer

This block holds two identical 24-bit down-counters behind a simple synchronous register bus. Each timer has its own 32-byte register window and its own interrupt line. Software writes a start value and then a control word. The control word selects whether the timer runs, whether it reloads itself after it expires, and how many clock cycles make up one count step (1, 16 or 256). Reading the count register shows the value falling over time. An interrupt stays raised until software writes to that timer's clear register.

Each timer is a small state machine with three states. `TS_OFF` means stopped: the count is held. `TS_COUNT` means the prescaler runs and the counter steps down. `TS_DONE` means a one-shot timer has expired and now holds zero. The transitions are as follows:
- *start*: a control write with the enable bit set moves any state to `TS_COUNT`.
- *stop*: a control write with the enable bit clear moves any state to `TS_OFF`.
- *rearm*: a load write moves `TS_DONE` to `TS_COUNT`. A load write leaves `TS_OFF` unchanged.
- *expire*: a prescaled step taken at a count of 1 or 0 in one-shot mode moves `TS_COUNT` to `TS_DONE`.

In periodic mode the same step reloads the count from the load register, and the timer stays in `TS_COUNT`. Reads are combinational from the address, so read data is valid in the same cycle as the address.

Top module: `dual_dtimer`

## Requirements
- R1: After reset every register of both timers reads 0 and both interrupt outputs are low.
- R2: Address bit 5 selects the timer (0x00 first, 0x20 second). Address bits 4:2 select the register: 0 is load, 1 is current count, 2 is control, 3 is interrupt clear. Indices 4 to 7, and the clear register, read 0. Address bits 1:0 are ignored.
- R3: A write to the load register sets both the load value and the current count to write data bits 23:0. Upper bits are dropped.
- R4: Control bit 7 is enable and bit 6 is periodic; with bit 6 clear the timer is one-shot. Bits 3:2 are the prescale select. Control read-back returns only these four bits, and all other bits read 0.
- R5: While enabled, the count falls by one every D cycles. D is 1, 16 or 256 for select 0, 1 or 2, and select 3 acts as 256. The first step lands D cycles after the write that started the timer.
- R6: A step taken at a count of 1 raises that timer's interrupt at the same clock edge at which the count changes.
- R7: In one-shot mode an expired timer holds a count of 0 and raises no further interrupts until a load or control write.
- R8: In periodic mode a step taken at a count of 1 (or 0) reloads the count from the load register, so with load value N an interrupt comes every N steps.
- R9: Any write to a timer's clear register drops its interrupt at the next edge. An expiry in the same cycle takes priority and keeps the interrupt set.
- R10: Clearing the enable bit freezes the count. Setting it again resumes counting from the held value.
- R11: A load or control write restarts that timer's prescale phase. Writes to one timer never change the other timer's registers, count or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Byte address of the register access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tmr_irq | output | 2 | Interrupt line per timer, bit i for timer i |

## Verification
The bound checker watches four behaviours on every cycle for each timer:
- the count moves only on a prescaled step or a load write;
- a step at a count of 1 raises the interrupt;
- a clear write drops the interrupt unless an expiry happens in the same cycle;
- an expired one-shot timer stays at zero.

The prescale spacing of 1, 16 and 256 cycles, the periodic reload period, the freeze and resume under the enable bit, and the control read-back mask need whole scenarios. The bench shows these by comparing every read and both interrupt lines against its behavioural model, and by directed checks on hand-computed counts.

// File: rtl/dtm_pkg.sv
package dtm_pkg;

    // Per-timer run state
    typedef enum logic [1:0] {
        TS_OFF   = 2'd0,
        TS_COUNT = 2'd1,
        TS_DONE  = 2'd2
    } tmr_state_e;

    // Register index inside a timer window (address bits 4:2)
    localparam logic [2:0] RIX_LOAD  = 3'd0;
    localparam logic [2:0] RIX_COUNT = 3'd1;
    localparam logic [2:0] RIX_CTRL  = 3'd2;
    localparam logic [2:0] RIX_CLEAR = 3'd3;

    // Control word field positions
    localparam int CTL_EN_BIT  = 7;
    localparam int CTL_PER_BIT = 6;
    localparam int CTL_DIV_LSB = 2;

    // Prescale counter width (largest divide is 256)
    localparam int PRE_W = 8;

    // Last prescale phase for a select code; code 3 acts as divide by 256
    function automatic logic [PRE_W-1:0] div_last(input logic [1:0] sel);
        logic [PRE_W-1:0] r;
        unique case (sel)
            2'd0:    r = 8'd0;
            2'd1:    r = 8'd15;
            default: r = 8'd255;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dtm_prescaler.sv
module dtm_prescaler
    import dtm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] sel,
    output logic       tick
);

    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] last;

    assign last = div_last(sel);
    assign tick = run && !restart && (phase_q == last);

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= (phase_q == last) ? '0 : phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/dtm_channel.sv
module dtm_channel
    import dtm_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_load,
    input  logic             wr_ctrl,
    input  logic             wr_clr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] load_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             en_q,
    output logic             per_q,
    output logic [1:0]       psel_q,
    output logic             irq_q,
    output logic             tick
);

    tmr_state_e st_q, st_nxt;
    logic       restart;
    logic       at_floor;
    logic       expire;

    assign restart  = wr_load || wr_ctrl;
    assign at_floor = tick && (cnt_q <= CNT_W'(1));
    assign expire   = tick && (cnt_q == CNT_W'(1));

    dtm_prescaler u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q == TS_COUNT),
        .restart (restart),
        .sel     (psel_q),
        .tick    (tick)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= TS_OFF;
        else        st_q <= st_nxt;
    end

    // Next-state: start / stop / rearm / expire
    always_comb begin
        st_nxt = st_q;
        if (wr_ctrl) begin
            st_nxt = wdata[CTL_EN_BIT] ? TS_COUNT : TS_OFF;
        end else if (wr_load) begin
            st_nxt = (st_q == TS_OFF) ? TS_OFF : TS_COUNT;
        end else begin
            unique case (st_q)
                TS_OFF:   st_nxt = TS_OFF;
                TS_COUNT: if (at_floor && !per_q) st_nxt = TS_DONE;
                TS_DONE:  st_nxt = TS_DONE;
                default:  st_nxt = TS_OFF;
            endcase
        end
    end

    // Registers, count and interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q <= '0;
            cnt_q  <= '0;
            en_q   <= 1'b0;
            per_q  <= 1'b0;
            psel_q <= 2'd0;
            irq_q  <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                en_q   <= wdata[CTL_EN_BIT];
                per_q  <= wdata[CTL_PER_BIT];
                psel_q <= wdata[CTL_DIV_LSB +: 2];
            end
            if (wr_load) begin
                load_q <= wdata;
                cnt_q  <= wdata;
            end else if (tick) begin
                if (at_floor) cnt_q <= per_q ? load_q : '0;
                else          cnt_q <= cnt_q - 1'b1;
            end
            if (expire)      irq_q <= 1'b1;
            else if (wr_clr) irq_q <= 1'b0;
        end
    end

endmodule

// File: rtl/dual_dtimer.sv
module dual_dtimer
    import dtm_pkg::*;
#(
    parameter int NUM_TMR = 2,
    parameter int CNT_W   = 24,
    parameter int DATA_W  = 32,
    parameter int WIN_AW  = 5,
    parameter int ADDR_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [NUM_TMR-1:0] tmr_irq
);

    localparam int SEL_W = ADDR_W - WIN_AW;

    logic [SEL_W-1:0]                 rd_sel;
    logic [2:0]                       rix;
    logic [NUM_TMR-1:0][CNT_W-1:0]    ch_cnt;
    logic [NUM_TMR-1:0][CNT_W-1:0]    ch_load;
    logic [NUM_TMR-1:0]               ch_en;
    logic [NUM_TMR-1:0]               ch_per;
    logic [NUM_TMR-1:0][1:0]          ch_psel;
    logic [NUM_TMR-1:0]               ch_tick;
    logic [NUM_TMR-1:0][DATA_W-1:0]   ch_rd;
    logic                             unused_bits;

    assign rd_sel      = bus_addr[ADDR_W-1:WIN_AW];
    assign rix         = bus_addr[4:2];
    assign unused_bits = ^{bus_wdata[DATA_W-1:CNT_W], bus_addr[1:0]};

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_ch
        logic hit;
        assign hit = bus_we && (rd_sel == SEL_W'(i));

        dtm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_load (hit && (rix == RIX_LOAD)),
            .wr_ctrl (hit && (rix == RIX_CTRL)),
            .wr_clr  (hit && (rix == RIX_CLEAR)),
            .wdata   (bus_wdata[CNT_W-1:0]),
            .load_q  (ch_load[i]),
            .cnt_q   (ch_cnt[i]),
            .en_q    (ch_en[i]),
            .per_q   (ch_per[i]),
            .psel_q  (ch_psel[i]),
            .irq_q   (tmr_irq[i]),
            .tick    (ch_tick[i])
        );

        always_comb begin
            ch_rd[i] = '0;
            unique case (rix)
                RIX_LOAD:  ch_rd[i][CNT_W-1:0] = ch_load[i];
                RIX_COUNT: ch_rd[i][CNT_W-1:0] = ch_cnt[i];
                RIX_CTRL: begin
                    ch_rd[i][CTL_EN_BIT]          = ch_en[i];
                    ch_rd[i][CTL_PER_BIT]         = ch_per[i];
                    ch_rd[i][CTL_DIV_LSB +: 2]    = ch_psel[i];
                end
                default:   ch_rd[i] = '0;
            endcase
        end
    end

    assign bus_rdata = ch_rd[rd_sel];

endmodule

// File: rtl/dtm_checker.sv
module dtm_checker #(
    parameter int NUM_TMR = 2,
    parameter int CNT_W   = 24,
    parameter int WIN_AW  = 5,
    parameter int ADDR_W  = 6
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic                          bus_we,
    input logic [NUM_TMR-1:0]            tmr_irq,
    input logic [NUM_TMR-1:0][CNT_W-1:0] ch_cnt,
    input logic [NUM_TMR-1:0]            ch_per,
    input logic [NUM_TMR-1:0]            ch_tick
);

    localparam int SEL_W = ADDR_W - WIN_AW;

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
        logic wl, wclr;
        assign wl   = bus_we && (bus_addr[ADDR_W-1:WIN_AW] == SEL_W'(i)) && (bus_addr[4:2] == 3'd0);
        assign wclr = bus_we && (bus_addr[ADDR_W-1:WIN_AW] == SEL_W'(i)) && (bus_addr[4:2] == 3'd3);

        // R5
        count_moves_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_tick[i] && !wl) |=> $stable(ch_cnt[i]));

        // R6
        expiry_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_tick[i] && ch_cnt[i] == CNT_W'(1)) |=> tmr_irq[i]);

        // R9
        clear_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wclr && !(ch_tick[i] && ch_cnt[i] == CNT_W'(1))) |=> !tmr_irq[i]);

        // R7
        oneshot_holds_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_per[i] && ch_cnt[i] == '0 && !wl) |=> (ch_cnt[i] == '0));
    end

endmodule

bind dual_dtimer dtm_checker #(
    .NUM_TMR (NUM_TMR),
    .CNT_W   (CNT_W),
    .WIN_AW  (WIN_AW),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .tmr_irq  (tmr_irq),
    .ch_cnt   (ch_cnt),
    .ch_per   (ch_per),
    .ch_tick  (ch_tick)
);

// File: tb/sim_dual_dtimer.sv
`timescale 1ns/100ps
module sim_dual_dtimer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  tmr_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;   // 250 MHz

    dual_dtimer u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_irq(tmr_irq)
    );

    // ---------------- behavioural reference model ----------------
    int m_load[2], m_cnt[2], m_psel[2], m_phase[2];
    bit m_en[2], m_per[2], m_done[2], m_irq[2];

    function automatic int divisor(int s);
        return (s == 0) ? 1 : (s == 1) ? 16 : 256;
    endfunction

    always @(posedge clk) begin
        for (int t = 0; t < 2; t++) begin
            if (!rst_n) begin
                m_load[t] = 0; m_cnt[t] = 0; m_psel[t] = 0; m_phase[t] = 0;
                m_en[t] = 0; m_per[t] = 0; m_done[t] = 0; m_irq[t] = 0;
            end else begin
                bit mine, wl, wc, wx, running, step, set_irq;
                int d;
                mine    = bus_we && (bus_addr[5] == t[0]);
                wl      = mine && bus_addr[4:2] == 0;
                wc      = mine && bus_addr[4:2] == 2;
                wx      = mine && bus_addr[4:2] == 3;
                d       = divisor(m_psel[t]);
                running = m_en[t] && !m_done[t];
                step    = running && !(wl || wc) && (m_phase[t] == d - 1);
                set_irq = 0;
                if (wl || wc) m_phase[t] = 0;
                else if (running) m_phase[t] = (m_phase[t] == d - 1) ? 0 : m_phase[t] + 1;
                if (wl) begin
                    m_load[t] = bus_wdata & 32'hFF_FFFF;
                    m_cnt[t]  = m_load[t];
                    m_done[t] = 0;
                end
                if (wc) begin
                    m_en[t]   = bus_wdata[7];
                    m_per[t]  = bus_wdata[6];
                    m_psel[t] = bus_wdata[3:2];
                    m_done[t] = 0;
                end
                if (step) begin
                    if (m_cnt[t] == 1) set_irq = 1;
                    if (m_cnt[t] <= 1) begin
                        m_cnt[t] = m_per[t] ? m_load[t] : 0;
                        if (!m_per[t]) m_done[t] = 1;
                    end else m_cnt[t] = m_cnt[t] - 1;
                end
                if (set_irq) m_irq[t] = 1;
                else if (wx) m_irq[t] = 0;
            end
        end
    end

    function automatic logic [31:0] model_read(logic [5:0] a);
        int t;
        t = a[5];
        case (a[4:2])
            3'd0: return m_load[t];
            3'd1: return m_cnt[t];
            3'd2: return {24'd0, m_en[t], m_per[t], 2'b00, m_psel[t][1:0], 2'b00};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string read_tag(logic [5:0] a);
        case (a[4:2])
            3'd0: return "R3";
            3'd1: return "R5";
            3'd2: return "R4";
            default: return "R2";
        endcase
    endfunction

    // every-cycle comparison, mid low phase
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            logic [31:0] exp_rd;
            exp_rd = model_read(bus_addr);
            checks++;
            if (bus_rdata !== exp_rd) begin
                fails++;
                $display("FAIL %s read addr=%h actual=%h expected=%h", read_tag(bus_addr), bus_addr, bus_rdata, exp_rd);
            end
            checks++;
            if (tmr_irq !== {m_irq[1], m_irq[0]}) begin
                fails++;
                $display("FAIL R6 irq actual=%b expected=%b", tmr_irq, {m_irq[1], m_irq[0]});
            end
        end
    end

    // ---------------- directed helpers ----------------
    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.2;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #(4.0 * 200000);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v, held;
        wait_cyc(4);
        rst_n = 1'b1;
        // R1: reset state
        for (int a = 0; a < 64; a += 4) begin
            if (a % 8 == 0) @(negedge clk);
            rd(6'(a), v);
            chk("R1 reset register", v, 32'd0);
        end
        chk("R1 reset irq", {30'd0, tmr_irq}, 32'd0);

        // Timer 0 one-shot, divide 1, load 5
        @(negedge clk);
        wr(6'h00, 32'd5);
        wr(6'h08, 32'h80);
        wait_cyc(2);
        rd(6'h04, v); chk("R5 div1 after 2 steps", v, 32'd3);
        wait_cyc(3);
        rd(6'h04, v); chk("R6 count at expiry", v, 32'd0);
        chk("R6 irq0 raised", {31'd0, tmr_irq[0]}, 32'd1);
        wait_cyc(10);
        rd(6'h04, v); chk("R7 one-shot holds zero", v, 32'd0);
        chk("R7 irq0 still set", {31'd0, tmr_irq[0]}, 32'd1);
        wr(6'h0C, 32'hDEAD);
        chk("R9 clear drops irq0", {31'd0, tmr_irq[0]}, 32'd0);

        // Timer 1 periodic, divide 16, load 3
        wr(6'h20, 32'd3);
        wr(6'h28, 32'hC4);
        wait_cyc(47);
        rd(6'h24, v); chk("R5 div16 two steps", v, 32'd1);
        chk("R8 no irq1 yet", {31'd0, tmr_irq[1]}, 32'd0);
        wait_cyc(1);
        rd(6'h24, v); chk("R8 periodic reload", v, 32'd3);
        chk("R8 irq1 raised", {31'd0, tmr_irq[1]}, 32'd1);
        rd(6'h00, v); chk("R11 timer0 load untouched", v, 32'd5);
        chk("R11 irq0 untouched", {31'd0, tmr_irq[0]}, 32'd0);
        wr(6'h2C, 32'd0);
        chk("R9 clear drops irq1", {31'd0, tmr_irq[1]}, 32'd0);
        wait_cyc(47);
        chk("R8 second period irq1", {31'd0, tmr_irq[1]}, 32'd1);
        wr(6'h2C, 32'd0);

        // R10: freeze and resume timer 1
        wr(6'h28, 32'h04);
        rd(6'h24, held);
        chk("R10 held value", held, 32'd3);
        wait_cyc(40);
        rd(6'h24, v); chk("R10 frozen while disabled", v, held);
        wr(6'h28, 32'h84);
        wait_cyc(16);
        rd(6'h24, v); chk("R10 resumes from held value", v, held - 1);

        // R4 read-back mask and select 3 as divide 256 on timer 0
        wr(6'h08, 32'hFFFF_FFFF);
        rd(6'h08, v); chk("R4 control read-back mask", v, 32'hCC);
        wait_cyc(255);
        rd(6'h04, v); chk("R5 select 3 before step", v, 32'd0);
        wait_cyc(1);
        rd(6'h04, v); chk("R5 select 3 step at 256 reloads", v, 32'd5);
        chk("R6 no irq from step at zero", {31'd0, tmr_irq[0]}, 32'd0);

        // R3 / R2 decode details
        wr(6'h20, 32'hAB12_3456);
        rd(6'h20, v); chk("R3 load truncated", v, 32'h0012_3456);
        rd(6'h25, v); chk("R2 low address bits ignored", v, 32'h0012_3456);
        rd(6'h34, v); chk("R2 unused offset reads zero", v, 32'd0);

        // R11 restart: control write restarts prescale phase
        wr(6'h28, 32'h84);
        wait_cyc(15);
        rd(6'h24, v); chk("R11 no step before 16 cycles", v, 32'h0012_3456);
        wait_cyc(1);
        rd(6'h24, v); chk("R11 step at 16 after restart", v, 32'h0012_3455);

        // mixed traffic against the model
        for (int n = 0; n < 4000; n++) begin
            logic [5:0] a;
            logic [31:0] d;
            a = 6'($urandom);
            if (($urandom % 6) == 0) begin
                if (a[4:2] == 3'd0) d = $urandom % 24;
                else begin
                    d = $urandom;
                    if (($urandom % 4) != 0) d[3:2] = 2'd0;
                end
                bus_addr = a; bus_wdata = d; bus_we = 1'b1;
            end else begin
                bus_addr = a; bus_we = 1'b0;
            end
            @(negedge clk);
        end
        bus_we = 1'b0;
        wait_cyc(4);
        done = 1;
        summary();
        $finish;
    end

endmodule